// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block moves a programmed number of words between one device location and a block of memory without the processor touching the data. Software sets up the transfer through a small register port: the direction, the device address, the first memory address and the word count. It then issues a start command, and the engine runs the transfer on its own.

For every word, the engine raises a bus request and waits for the grant. It then spends two single-cycle bus accesses on that word: a read from the source and a write to the destination. After that it drops the request for at least one cycle, so the processor gets the bus back between words and is delayed only at its own next bus access. Once the last word has been written, the engine flags completion and holds an interrupt line high until software acknowledges it.

Top module: `cycle_dma`

## Requirements
- R1: After reset, the status read returns busy=0 and done=0, `irq` is low, and `busReq` and `busValid` are low.
- R2: While the engine is idle, the registers read back what was written to them. Register 0 (control) holds the direction in bit 1, where 0 means device to memory and 1 means memory to device. Register 1 holds the device address, register 2 the memory address and register 3 the word count. Register 4 (status) returns busy in bit 0 and done in bit 1.
- R3: `busValid` is asserted only in a cycle where both `busReq` and `busGrant` are high. While `busGrant` is low, the engine waits with the request held.
- R4: The engine raises `busReq` exactly once per word. It drops the request in the cycle after that word's write access.
- R5: Each word takes exactly two bus accesses: a read of the source (`busWrite`=0) followed in the next cycle by a write of the same data to the destination (`busWrite`=1). `busSpace`=1 selects the device and `busSpace`=0 selects memory, so every word is copied in order.
- R6: After each word, the memory address advances by one and the remaining count falls by one. Every device access uses the unchanged device address. When the transfer ends, register 2 reads start+N and register 3 reads 0.
- R7: When the count reaches zero, busy clears and done and `irq` go high. Writing a 1 to bit 1 of the status register clears both done and `irq`.
- R8: A start command with a count of zero sets done and `irq` in the next cycle and produces no bus access.
- R9: While busy, writes to the control, device address, memory address and count registers are ignored, including a second start command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data for the selected register (combinational) |
| busReq | output | 1 | Bus request |
| busGrant | input | 1 | Bus grant; held by the arbiter while `busReq` stays high |
| busValid | output | 1 | Bus access in this cycle |
| busWrite | output | 1 | 1 = write access, 0 = read access |
| busSpace | output | 1 | 1 = device, 0 = memory |
| busAddr | output | ADDR_W | Access address |
| busWdata | output | DATA_W | Write data |
| busRdata | input | DATA_W | Read data, returned in the same cycle |
| irq | output | 1 | Completion interrupt, level |

## Verification
The assertions check the bus handshake in every cycle: no access without both request and grant, a write access always directly after a read access, and the request dropped after each write. They also check that the interrupt never coincides with an active request. Only the bench's scenarios can show that the data arrives intact and in order, that the device address stays fixed, and how the addresses and count end up. The same holds for the zero-count shortcut and for writes made while the engine is busy being ignored. The bench shows these under random grant delays and random transfer parameters in both directions.

// File: rtl/cycle_dma_pkg.sv
package cycle_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_READ,
    ST_WRITE,
    ST_REL
  } dmaState_t;

  typedef struct packed {
    logic busCycle;
    logic writePhase;
    logic captureWord;
    logic advance;
  } dmaStrobe_t;

  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_DEV    = 3'd1;
  localparam logic [2:0] REG_MEM    = 3'd2;
  localparam logic [2:0] REG_COUNT  = 3'd3;
  localparam logic [2:0] REG_STATUS = 3'd4;

  localparam int BIT_START = 0;
  localparam int BIT_DIR   = 1;
  localparam int BIT_BUSY  = 0;
  localparam int BIT_DONE  = 1;
endpackage

// File: rtl/cycle_dma_ctrl.sv
module cycle_dma_ctrl
  import cycle_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startCmd,
  input  logic       clearDone,
  input  logic       countZero,
  input  logic       busGrant,
  output logic       busReq,
  output logic       busy,
  output logic       done,
  output dmaStrobe_t strobe
);
  dmaState_t state, stateNext;
  logic doneSet;

  always_comb begin
    stateNext = state;
    doneSet   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startCmd) begin
          if (countZero) doneSet = 1'b1;
          else           stateNext = ST_REQ;
        end
      end
      ST_REQ:   if (busGrant) stateNext = ST_READ;
      ST_READ:  stateNext = ST_WRITE;
      ST_WRITE: stateNext = ST_REL;
      ST_REL: begin
        if (countZero) begin
          stateNext = ST_IDLE;
          doneSet   = 1'b1;
        end else begin
          stateNext = ST_REQ;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      if (doneSet)                     done <= 1'b1;
      else if (clearDone || startCmd)  done <= 1'b0;
    end
  end

  always_comb begin
    strobe.busCycle    = (state == ST_READ) || (state == ST_WRITE);
    strobe.writePhase  = (state == ST_WRITE);
    strobe.captureWord = (state == ST_READ);
    strobe.advance     = (state == ST_WRITE);
  end

  assign busReq = (state == ST_REQ) || (state == ST_READ) || (state == ST_WRITE);
  assign busy   = (state != ST_IDLE);
endmodule

// File: rtl/cycle_dma_path.sv
module cycle_dma_path
  import cycle_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              busy,
  input  logic              done,
  input  dmaStrobe_t        strobe,
  output logic              startCmd,
  output logic              clearDone,
  output logic              countZero,
  output logic              busValid,
  output logic              busWrite,
  output logic              busSpace,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata
);
  logic              memToDev;
  logic [ADDR_W-1:0] devAddr;
  logic [ADDR_W-1:0] memAddr;
  logic [CNT_W-1:0]  remaining;
  logic [DATA_W-1:0] dataHold;
  logic              accept;
  logic              accessDev;

  assign accept    = regWe && !busy;
  assign startCmd  = accept && (regAddr == REG_CTRL) && regWdata[BIT_START];
  assign clearDone = regWe && (regAddr == REG_STATUS) && regWdata[BIT_DONE];
  assign countZero = (remaining == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memToDev  <= 1'b0;
      devAddr   <= '0;
      memAddr   <= '0;
      remaining <= '0;
      dataHold  <= '0;
    end else begin
      if (accept) begin
        unique case (regAddr)
          REG_CTRL:  memToDev  <= regWdata[BIT_DIR];
          REG_DEV:   devAddr   <= ADDR_W'(regWdata);
          REG_MEM:   memAddr   <= ADDR_W'(regWdata);
          REG_COUNT: remaining <= CNT_W'(regWdata);
          default: ;
        endcase
      end
      if (strobe.captureWord) dataHold <= busRdata;
      if (strobe.advance) begin
        memAddr   <= memAddr + 1'b1;
        remaining <= remaining - 1'b1;
      end
    end
  end

  // source is read first, destination written second
  assign accessDev = strobe.writePhase ? memToDev : !memToDev;
  assign busValid  = strobe.busCycle;
  assign busWrite  = strobe.writePhase;
  assign busSpace  = strobe.busCycle && accessDev;
  assign busAddr   = !strobe.busCycle ? '0 : (accessDev ? devAddr : memAddr);
  assign busWdata  = strobe.writePhase ? dataHold : '0;

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      REG_CTRL:   regRdata[BIT_DIR] = memToDev;
      REG_DEV:    regRdata = DATA_W'(devAddr);
      REG_MEM:    regRdata = DATA_W'(memAddr);
      REG_COUNT:  regRdata = DATA_W'(remaining);
      REG_STATUS: begin
        regRdata[BIT_BUSY] = busy;
        regRdata[BIT_DONE] = done;
      end
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/cycle_dma.sv
module cycle_dma
  import cycle_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              busReq,
  input  logic              busGrant,
  output logic              busValid,
  output logic              busWrite,
  output logic              busSpace,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  dmaStrobe_t strobe;
  logic startCmd, clearDone, countZero, busy, done;

  cycle_dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .clearDone(clearDone),
    .countZero(countZero), .busGrant(busGrant), .busReq(busReq),
    .busy(busy), .done(done), .strobe(strobe)
  );

  cycle_dma_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_path (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy), .done(done),
    .strobe(strobe), .startCmd(startCmd), .clearDone(clearDone),
    .countZero(countZero), .busValid(busValid), .busWrite(busWrite),
    .busSpace(busSpace), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata)
  );

  assign irq = done;
endmodule

// File: rtl/cycle_dma_chk.sv
module cycle_dma_chk (
  input logic clk,
  input logic rstN,
  input logic busReq,
  input logic busGrant,
  input logic busValid,
  input logic busWrite,
  input logic irq
);
  assert_bus_owned_R3: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busReq && busGrant));

  assert_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite) |=> !busReq);

  assert_read_then_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> (busValid && busWrite));

  assert_write_after_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite) |-> $past(busValid && !busWrite));

  assert_irq_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !busReq);
endmodule

bind cycle_dma cycle_dma_chk u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busGrant(busGrant),
  .busValid(busValid), .busWrite(busWrite), .irq(irq)
);

// File: tb/cycle_dma_test.sv
module cycle_dma_test;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [DW-1:0] regWdata = '0;
  logic [DW-1:0] regRdata;
  logic busReq, busValid, busWrite, busSpace, irq;
  logic busGrant = 1'b0;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata, busRdata;

  int total = 0;
  int bad = 0;

  // bench bus model
  logic [DW-1:0] mem [256];
  logic [DW-1:0] devLog [4096];
  logic [DW-1:0] devSeq = 16'h0100;
  int logIdx = 0;
  int reqRises = 0, accCount = 0, noGrant = 0, devAddrBad = 0;
  logic prevReq = 1'b0;
  logic [AW-1:0] expDev = '0;

  always #2 clk = ~clk;

  cycle_dma uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busReq(busReq),
    .busGrant(busGrant), .busValid(busValid), .busWrite(busWrite),
    .busSpace(busSpace), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq)
  );

  assign busRdata = busSpace ? devSeq : mem[busAddr[7:0]];

  function automatic logic [DW-1:0] fillVal(int i);
    return DW'(i * 37 + 5);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= fillVal(i);
    end else if (busValid) begin
      if (busWrite) begin
        if (busSpace) begin
          devLog[logIdx] <= busWdata;
          logIdx <= logIdx + 1;
        end else begin
          mem[busAddr[7:0]] <= busWdata;
        end
      end else if (busSpace) begin
        devSeq <= devSeq + 1'b1;
      end
    end
  end

  // arbiter model and bus monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (busReq && !prevReq) reqRises++;
      prevReq = busReq;
      if (busValid) begin
        accCount++;
        if (!busGrant || !busReq) noGrant++;
        if (busSpace && busAddr != expDev) devAddrBad++;
      end
    end
    if (!busReq) busGrant = 1'b0;
    else if (!busGrant && ($urandom % 3 == 0)) busGrant = 1'b1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [DW-1:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitIrq(int limit);
    for (int i = 0; i < limit && !irq; i++) @(negedge clk);
  endtask

  task automatic runXfer(bit dir, logic [AW-1:0] dev, logic [AW-1:0] m, int n, bit poke);
    logic [DW-1:0] v;
    logic [DW-1:0] snap [256];
    logic [DW-1:0] seq0;
    int log0, rise0, acc0, ng0, da0;
    for (int i = 0; i < 256; i++) snap[i] = mem[i];
    seq0 = devSeq; log0 = logIdx; rise0 = reqRises; acc0 = accCount;
    ng0 = noGrant; da0 = devAddrBad;
    expDev = dev;
    wr(3'd1, dev);
    wr(3'd2, m);
    wr(3'd3, DW'(n));
    wr(3'd0, {14'd0, dir, 1'b1});
    if (poke) begin
      rd(3'd4, v);
      check("R9 busy during transfer", 32'(v[0]), 32'd1);
      wr(3'd2, 16'h00F0);
      wr(3'd3, 16'd99);
      wr(3'd1, 16'hBEEF);
      wr(3'd0, {14'd0, !dir, 1'b1});
    end
    waitIrq(4000);
    check("R7 irq at completion", 32'(irq), 32'd1);
    rd(3'd4, v);
    check("R7 status done, not busy", 32'(v[1:0]), 32'd2);
    rd(3'd2, v);
    check("R6 final memory address", 32'(v), 32'(m + AW'(n)));
    rd(3'd3, v);
    check("R6 final count", 32'(v), 32'd0);
    rd(3'd1, v);
    check("R9 device address kept", 32'(v), 32'(dev));
    check("R4 one request per word", 32'(reqRises - rise0), 32'(n));
    check("R5 two accesses per word", 32'(accCount - acc0), 32'(2 * n));
    check("R3 access only when granted", 32'(noGrant - ng0), 32'd0);
    check("R6 device address fixed", 32'(devAddrBad - da0), 32'd0);
    if (!dir) begin
      for (int i = 0; i < n; i++)
        check("R5 device to memory data", 32'(mem[(m + AW'(i)) & 16'hFF]), 32'(seq0 + DW'(i)));
    end else begin
      for (int i = 0; i < n; i++)
        check("R5 memory to device data", 32'(devLog[log0 + i]), 32'(snap[(m + AW'(i)) & 16'hFF]));
    end
    wr(3'd4, 16'h0002);
    check("R7 irq cleared", 32'(irq), 32'd0);
    rd(3'd4, v);
    check("R7 done cleared", 32'(v), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    int acc0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd4, v);
    check("R1 status after reset", 32'(v), 32'd0);
    check("R1 irq after reset", 32'(irq), 32'd0);
    check("R1 busReq after reset", 32'(busReq), 32'd0);
    check("R1 busValid after reset", 32'(busValid), 32'd0);

    // R2 readback while idle
    wr(3'd0, 16'h0002);
    rd(3'd0, v);
    check("R2 direction readback", 32'(v), 32'd2);
    wr(3'd1, 16'h1234); rd(3'd1, v); check("R2 device readback", 32'(v), 32'h1234);
    wr(3'd2, 16'h0042); rd(3'd2, v); check("R2 memory readback", 32'(v), 32'h42);
    wr(3'd3, 16'h0007); rd(3'd3, v); check("R2 count readback", 32'(v), 32'd7);
    wr(3'd0, 16'h0000);

    // R8 zero count
    wr(3'd3, 16'd0);
    acc0 = accCount;
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'd0; regWdata = 16'h0001;
    @(negedge clk);
    regWe = 1'b0;
    check("R8 irq one cycle after start", 32'(irq), 32'd1);
    rd(3'd4, v);
    check("R8 done without busy", 32'(v), 32'd2);
    repeat (4) @(negedge clk);
    check("R8 no bus access", 32'(accCount - acc0), 32'd0);
    wr(3'd4, 16'h0002);
    check("R8 irq cleared", 32'(irq), 32'd0);

    // directed transfers
    runXfer(1'b0, 16'h0033, 16'h0010, 1, 1'b0);
    runXfer(1'b1, 16'h0044, 16'h0020, 5, 1'b0);
    runXfer(1'b0, 16'h0055, 16'h0080, 8, 1'b1);   // R9 writes while busy
    runXfer(1'b1, 16'h0066, 16'h00A0, 6, 1'b1);

    // random transfers
    for (int k = 0; k < 10; k++) begin
      runXfer(1'($urandom % 2), AW'($urandom % 65536), AW'($urandom % 200),
              1 + int'($urandom % 40), 1'($urandom % 2));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule